// File: doc/BRIEF.md
# Static Memory Write Cycle Controller

This block runs one write access on an asynchronous external memory bus. It is clocked by the bus clock. On the internal side, a request starts an access and a one-cycle ready pulse reports that it has finished. The write wait-state count comes from a configuration input and is captured when the request is accepted. On the external side, the block drives the active-low chip select and write enable. It also takes an active-low wait input that lets a slow device stretch the access.

While the access runs, a countdown counts off the programmed wait states. The wait input passes through a two-flop synchroniser and is acted on only once the countdown has reached 3. Before that point a low wait has no effect. From that point on, every synchronised low sample holds the countdown in place.

When wait comes back high after it has held the access, the access does not end at once. It runs through a fixed completion tail of five cycles, and then chip select and write enable release together. If wait stays low for longer than the allowed limit, a timeout flag is raised and the same completion tail is forced.

Top module: `smc_wr_ctrl`

## Requirements
- R1: After reset, cs_no and we_no are 1, and ready_o and timeout_o are 0.
- R2: A request is accepted only while the controller is idle. In the cycle after acceptance, cs_no and we_no both go low. A request made during an access is ignored: no second access follows.
- R3: The effective wait-state count W is wst_cfg_i, raised to 3 when it is below 3. It is captured at acceptance, so later changes to wst_cfg_i have no effect on the running access. With wait never low inside the window, cs_no stays low for exactly W+1 cycles.
- R4: A low wait_ni is ignored while the countdown is above 3, and it adds no cycles to the access.
- R5: Once the countdown has reached 3, each cycle in which the synchronised wait is low holds the countdown.
- R6: After such a hold, cs_no and we_no deassert on the 8th rising clock edge after wait_ni goes high: two synchroniser edges, one release edge, and a five-cycle tail.
- R7: we_no is never low while cs_no is high. The two signals deassert in the same cycle.
- R8: ready_o is high for exactly one cycle. That cycle is the first cycle in which cs_no is high again after an access.
- R9: If the synchronised wait stays low for 16,365 hold cycles, timeout_o goes to 1 and the five-cycle tail follows. With W=3 and wait held low, cs_no is therefore low for 16,370 cycles. timeout_o stays at 1 until the next request is accepted, and the acceptance clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Write access request |
| wst_cfg_i | input | CNT_W | Configured write wait-state count |
| ready_o | output | 1 | One-cycle pulse when the access ends |
| cs_no | output | 1 | Chip select, active low |
| we_no | output | 1 | Write enable, active low |
| wait_ni | input | 1 | External wait, active low, asynchronous |
| timeout_o | output | 1 | Wait held past the limit |

## Verification
The hardest case to reach is the timeout. It requires wait to stay low for the full 16,365-cycle limit inside the sampling window. The bench holds wait_ni low from before the request and uses the minimum wait-state count, so the very first countdown cycle already lies inside the window. The long hold then runs to expiry, and the bench checks the exact access length and that the flag stays set until the next acceptance. The boundary of the ignore window is reached by pulsing wait low just after acceptance with a long count, then timing the release against the synchroniser delay.

// File: rtl/smc_wr_pkg.sv
`timescale 1ns/1ps
package smc_wr_pkg;
  parameter int unsigned MIN_WST   = 3;  // lower clamp of the wait-state count
  parameter int unsigned WIN_POINT = 3;  // countdown value at which wait sampling starts

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_TAIL  = 2'd2
  } wr_state_e;
endpackage

// File: rtl/smc_wr_sync.sv
`timescale 1ns/1ps
module smc_wr_sync #(
  parameter int unsigned STAGES = 2,
  parameter bit          RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= {STAGES{RST_VAL}};
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/smc_wr_down_cnt.sv
`timescale 1ns/1ps
module smc_wr_down_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (dec_i)  cnt_q <= cnt_q - W'(1);
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/smc_wr_stall_timer.sv
`timescale 1ns/1ps
module smc_wr_stall_timer #(
  parameter int unsigned LIMIT = 16365
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic stall_i,
  output logic expire_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;
  logic          last;

  assign last = (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (stall_i && !last)  cnt_q <= cnt_q + CW'(1);
  end

  // the LIMIT-th consecutive hold cycle expires the wait
  assign expire_o = stall_i && last;
endmodule

// File: rtl/smc_wr_ctrl.sv
`timescale 1ns/1ps
module smc_wr_ctrl
  import smc_wr_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned STALL_MAX   = 16365,
  parameter int unsigned TAIL_LEN    = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [CNT_W-1:0] wst_cfg_i,
  output logic             ready_o,
  output logic             cs_no,
  output logic             we_no,
  input  logic             wait_ni,
  output logic             timeout_o
);
  localparam int unsigned TAIL_W = $clog2(TAIL_LEN + 1);

  wr_state_e state_q, state_d;

  logic             wait_s;
  logic [CNT_W-1:0] wst_eff;
  logic [CNT_W-1:0] wst_cnt;
  logic             wst_zero;
  logic [TAIL_W-1:0] tail_cnt;
  logic             tail_zero;
  logic             accept, in_win, stall, release_w, count_end, tail_end;
  logic             expire, go_tail, wst_dec, tail_dec;
  logic             seen_q, ready_q, timeout_q, cs_n_q, we_n_q;

  smc_wr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (wait_ni),
    .q_o   (wait_s)
  );

  assign wst_eff = (wst_cfg_i < CNT_W'(MIN_WST)) ? CNT_W'(MIN_WST) : wst_cfg_i;

  assign accept    = (state_q == ST_IDLE) && req_i;
  assign in_win    = (wst_cnt <= CNT_W'(WIN_POINT));
  assign stall     = (state_q == ST_COUNT) && in_win && !wait_s;
  assign release_w = (state_q == ST_COUNT) && in_win && wait_s && seen_q;
  assign count_end = (state_q == ST_COUNT) && in_win && wait_s && !seen_q && wst_zero;
  assign go_tail   = release_w || expire;
  assign tail_end  = (state_q == ST_TAIL) && tail_zero;
  assign wst_dec   = (state_q == ST_COUNT) && !stall && !go_tail && !count_end;
  assign tail_dec  = (state_q == ST_TAIL) && !tail_zero;

  smc_wr_down_cnt #(.W(CNT_W)) i_wst_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (accept),
    .load_val_i(wst_eff),
    .dec_i     (wst_dec),
    .cnt_o     (wst_cnt),
    .zero_o    (wst_zero)
  );

  smc_wr_down_cnt #(.W(TAIL_W)) i_tail_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (go_tail),
    .load_val_i(TAIL_W'(TAIL_LEN - 1)),
    .dec_i     (tail_dec),
    .cnt_o     (tail_cnt),
    .zero_o    (tail_zero)
  );

  smc_wr_stall_timer #(.LIMIT(STALL_MAX)) i_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (accept),
    .stall_i (stall),
    .expire_o(expire)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept) state_d = ST_COUNT;
      ST_COUNT: begin
        if (go_tail)        state_d = ST_TAIL;
        else if (count_end) state_d = ST_IDLE;
      end
      ST_TAIL:  if (tail_end) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      seen_q    <= 1'b0;
      ready_q   <= 1'b0;
      timeout_q <= 1'b0;
      cs_n_q    <= 1'b1;
      we_n_q    <= 1'b1;
    end else begin
      state_q <= state_d;
      ready_q <= count_end || tail_end;
      if (accept)     seen_q <= 1'b0;
      else if (stall) seen_q <= 1'b1;
      if (accept)      timeout_q <= 1'b0;
      else if (expire) timeout_q <= 1'b1;
      // zero write-enable delay: both strobes switch on the same edges
      if (accept)                     cs_n_q <= 1'b0;
      else if (count_end || tail_end) cs_n_q <= 1'b1;
      if (accept)                     we_n_q <= 1'b0;
      else if (count_end || tail_end) we_n_q <= 1'b1;
    end
  end

  assign ready_o   = ready_q;
  assign cs_no     = cs_n_q;
  assign we_no     = we_n_q;
  assign timeout_o = timeout_q;
endmodule

// File: rtl/smc_wr_ctrl_chk.sv
`timescale 1ns/1ps
module smc_wr_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ready_o,
  input logic cs_no,
  input logic we_no,
  input logic timeout_o
);
  a_r7_we_inside_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_no |-> !cs_no);

  a_r2_strobes_start_together: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> $fell(we_no));

  a_r3_min_access_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |=> !cs_no ##1 !cs_no ##1 !cs_no);

  a_r8_ready_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);

  a_r8_ready_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> ready_o);

  a_r9_timeout_in_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> !cs_no);
endmodule

bind smc_wr_ctrl smc_wr_ctrl_chk i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ready_o  (ready_o),
  .cs_no    (cs_no),
  .we_no    (we_no),
  .timeout_o(timeout_o)
);

// File: tb/test_smc_wr_ctrl.sv
`timescale 1ns/1ps
module test_smc_wr_ctrl;
  localparam int CNT_W = 8;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             req_i = 1'b0;
  logic [CNT_W-1:0] wst_cfg_i = '0;
  logic             wait_ni = 1'b1;
  logic             ready_o, cs_no, we_no, timeout_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  smc_wr_ctrl i_smc_wr_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .wst_cfg_i(wst_cfg_i),
    .ready_o  (ready_o),
    .cs_no    (cs_no),
    .we_no    (we_no),
    .wait_ni  (wait_ni),
    .timeout_o(timeout_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // request for one cycle; returns at the first negedge of the access
  task automatic start(input int cfg);
    @(negedge clk_i);
    req_i = 1'b1;
    wst_cfg_i = CNT_W'(cfg);
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  // counts low samples from the current negedge, then checks the ready pulse
  task automatic count_low(output int n);
    int bad_we = 0;
    n = 0;
    while (cs_no == 1'b0 && n < 20000) begin
      n++;
      if (we_no != cs_no) bad_we++;
      @(negedge clk_i);
    end
    if (we_no != cs_no) bad_we++;
    chk(bad_we == 0, "R7 we_no tracks cs_no", bad_we, 0);
    chk(ready_o == 1'b1, "R8 ready at end", ready_o, 1);
    @(negedge clk_i);
    chk(ready_o == 1'b0, "R8 ready one cycle", ready_o, 0);
  endtask

  task automatic t_reset();
    chk(cs_no == 1'b1 && we_no == 1'b1, "R1 strobes idle", {cs_no, we_no}, 3);
    chk(ready_o == 1'b0 && timeout_o == 1'b0, "R1 flags low", {ready_o, timeout_o}, 0);
  endtask

  task automatic t_plain(input int cfg, input int exp);
    int n;
    start(cfg);
    chk(cs_no == 1'b0 && we_no == 1'b0, "R2 strobes low after accept", {cs_no, we_no}, 0);
    count_low(n);
    chk(n == exp, "R3 access length", n, exp);
  endtask

  task automatic t_cfg_change();
    int n;
    start(9);
    @(negedge clk_i);
    wst_cfg_i = '0;
    count_low(n);
    chk(n + 1 == 10, "R3 cfg latched at accept", n + 1, 10);
  endtask

  task automatic t_busy_req();
    int n;
    int lows = 0;
    start(7);
    @(negedge clk_i);
    @(negedge clk_i);
    req_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
    count_low(n);
    chk(n + 3 == 8, "R2 busy request no stretch", n + 3, 8);
    for (int i = 0; i < 6; i++) begin
      if (cs_no == 1'b0) lows++;
      @(negedge clk_i);
    end
    chk(lows == 0, "R2 busy request ignored", lows, 0);
  endtask

  task automatic t_early_wait();
    int n;
    start(12);
    wait_ni = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    wait_ni = 1'b1;
    count_low(n);
    chk(n + 2 == 13, "R4 early wait ignored", n + 2, 13);
  endtask

  task automatic t_release(input int cfg, input int k);
    int n;
    wait_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    start(cfg);
    repeat (k - 1) @(negedge clk_i);
    chk(cs_no == 1'b0, "R5 held while wait low", cs_no, 0);
    wait_ni = 1'b1;
    @(negedge clk_i);
    count_low(n);
    chk(n == 7, "R6 release to end", n, 7);
  endtask

  task automatic t_timeout();
    int n;
    wait_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    start(3);
    count_low(n);
    chk(n == 16370, "R9 timeout access length", n, 16370);
    chk(timeout_o == 1'b1, "R9 timeout flag set", timeout_o, 1);
    wait_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    chk(timeout_o == 1'b1, "R9 timeout flag held", timeout_o, 1);
    start(5);
    chk(timeout_o == 1'b0, "R9 timeout cleared on accept", timeout_o, 0);
    count_low(n);
    chk(n == 6, "R3 access after timeout", n, 6);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_plain(7, 8);
    t_plain(12, 13);
    t_plain(0, 4);
    t_plain(2, 4);
    t_plain(3, 4);
    t_cfg_change();
    t_busy_req();
    t_early_wait();
    t_release(3, 10);
    t_release(20, 30);
    t_timeout();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule